// File: doc/BRIEF.md
# Isochronous Resource Lock Register Bank

This block keeps the four shared resource registers that nodes on a serial bus contend for: the bus-manager identity, the remaining isochronous bandwidth, and a 64-channel availability mask split into a high word and a low word. Remote agents reach them through a one-request-at-a-time interface. Each request carries an operation (read, write, 32-bit lock, 64-bit lock), a byte offset, an extended lock code and data/argument words. The reply carries a response code and the value the requester needs to see.

Locks are not all plain compare-and-swap. The bandwidth register runs an allocate/free rule with its own range checks. The channel words toggle only the bits on which argument and data differ, and only if the register agrees with the argument on those bits. Channel 31 (bit 0 of the high channel word) is reserved for broadcast and can never be released. A bus reset reloads every register to its default.

Control is a three-state machine. ST_IDLE accepts a request, which moves it to ST_REPLY. ST_REPLY shows the response for one cycle and then returns to ST_IDLE. ST_RELOAD is entered from any state while bus reset is high, holds the defaults, and leaves for ST_IDLE on the first cycle with bus reset low. Each accepted request is read, decided and committed in one clock edge, so requests are serialized with no interleaving.

Top module: `irm_lock_regs`

## Requirements
- R1: After rst_n or while bus_rst is high, the registers hold bus manager 0x3F, bandwidth 4915, channels high 0xFFFFFFFE and channels low 0xFFFFFFFF. After bus_rst falls, req_ready returns one cycle later.
- R2: A request is taken on a rising edge where req_valid and req_ready are high and bus_rst is low. rsp_valid is then high for exactly the next cycle, and req_ready is low during that cycle.
- R3: Register offsets are manager 0x21C, bandwidth 0x220, channels high 0x224 and channels low 0x228. Response codes are 0 complete, 1 type error and 2 address error. A read (op 0) of one of these offsets returns its value in rsp_data[31:0] with code 0. Any aligned offset outside the four returns code 2 for every operation.
- R4: A request whose offset has bits [1:0] not zero returns code 1 and changes nothing.
- R5: A write (op 1) to any of the four registers returns code 1 and leaves all of them unchanged.
- R6: A 32-bit lock (op 2) or 64-bit lock (op 3) whose extended code is not compare-swap (value 2) returns code 1 at a known offset.
- R7: A 32-bit compare-swap on the manager register returns the old value, and stores data[31:0] only when the old value equals arg[31:0].
- R8: A bandwidth lock with arg above 0x1FFF returns the old value and changes nothing. Only data bits [12:0] take part.
- R9: When arg is at least the masked data, the difference is subtracted if the register holds at least that much; the reply is arg on success and the old value otherwise.
- R10: When arg is below the masked data, the difference is added if the sum stays below 0x2000; the reply is arg on success and the old value otherwise.
- R11: A channel lock flips the bits set in arg XOR data when the register equals arg on those bits and replies with arg. Otherwise it leaves the register unchanged and replies with the current value.
- R12: Before any channel lock is evaluated, the data bit for bit 0 of channels high is forced to zero, so that bit stays zero.
- R13: A 64-bit compare-swap at the channels-high offset applies the R11 rule to {high, low} as one 64-bit word and replies in rsp_data[63:0]. A 64-bit lock at any other known offset returns code 1.
- R14: A request presented in the same cycle as bus_rst is dropped and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous bus reset; reloads defaults |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 lock32, 3 lock64 |
| req_addr | input | AW | Byte offset of the target register |
| req_ext | input | 4 | Extended lock code; 2 is compare-swap |
| req_data | input | 64 | New-value word (low 32 bits for 32-bit ops) |
| req_arg | input | 64 | Compare/argument word (low 32 bits for 32-bit ops) |
| rsp_valid | output | 1 | Response present |
| rsp_rcode | output | 2 | Response code |
| rsp_data | output | 64 | Read value or lock return value |

## Verification
A wrong register value stays hidden until the next read or lock of that register. The bench therefore reads every register back after each group of locks, and most faults show within two transactions. A lock rule that decides wrongly shows in the same response, as the argument returned where the old value was due or the reverse. A fault in the state machine shows within one cycle as a missing, doubled or early rsp_valid, or a req_ready that is wrong. Bus reset is checked both for the request it must drop and for the reloaded values read afterwards.

// File: rtl/irm_pkg.sv
`timescale 1ns/1ps
package irm_pkg;
    localparam int EXT_W     = 4;
    localparam int BW_BITS   = 13;
    localparam logic [EXT_W-1:0] EXT_CAS   = 4'd2;
    localparam logic [31:0]      MGR_INIT  = 32'h0000_003F;
    localparam logic [BW_BITS-1:0] BW_INIT = 13'd4915;
    localparam logic [31:0]      CHHI_INIT = 32'hFFFF_FFFE;
    localparam logic [31:0]      CHLO_INIT = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_LOCK32 = 2'd2,
        OP_LOCK64 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RC_COMPLETE = 2'd0,
        RC_TYPE_ERR = 2'd1,
        RC_ADDR_ERR = 2'd2
    } rcode_e;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_MGR, TGT_BW, TGT_CHHI, TGT_CHLO
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_REPLY, ST_RELOAD
    } state_e;
endpackage

// File: rtl/irm_decode.sv
`timescale 1ns/1ps
module irm_decode
    import irm_pkg::*;
#(
    parameter int AW = 12,
    parameter logic [AW-1:0] MGR_OFS  = 12'h21C,
    parameter logic [AW-1:0] BW_OFS   = 12'h220,
    parameter logic [AW-1:0] CHHI_OFS = 12'h224,
    parameter logic [AW-1:0] CHLO_OFS = 12'h228
) (
    input  op_e              op,
    input  logic [AW-1:0]    addr,
    input  logic [EXT_W-1:0] ext,
    output tgt_e             tgt,
    output rcode_e           rc
);
    logic aligned;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        if (addr == MGR_OFS)       tgt = TGT_MGR;
        else if (addr == BW_OFS)   tgt = TGT_BW;
        else if (addr == CHHI_OFS) tgt = TGT_CHHI;
        else if (addr == CHLO_OFS) tgt = TGT_CHLO;
        else                       tgt = TGT_NONE;
    end

    always_comb begin
        if (!aligned)
            rc = RC_TYPE_ERR;
        else if (tgt == TGT_NONE)
            rc = RC_ADDR_ERR;
        else begin
            unique case (op)
                OP_READ:   rc = RC_COMPLETE;
                OP_WRITE:  rc = RC_TYPE_ERR;
                OP_LOCK32: rc = (ext == EXT_CAS) ? RC_COMPLETE : RC_TYPE_ERR;
                OP_LOCK64: rc = (ext == EXT_CAS && tgt == TGT_CHHI)
                                ? RC_COMPLETE : RC_TYPE_ERR;
                default:   rc = RC_TYPE_ERR;
            endcase
        end
    end
endmodule

// File: rtl/irm_bw_rule.sv
`timescale 1ns/1ps
module irm_bw_rule
    import irm_pkg::*;
(
    input  logic [BW_BITS-1:0] cur,
    input  logic [31:0]        swp,
    input  logic [31:0]        cmp,
    output logic [BW_BITS-1:0] nxt,
    output logic [31:0]        ret
);
    localparam int HI_W = 32 - BW_BITS;

    logic               over;
    logic [BW_BITS-1:0] d_m, a_m, diff;
    logic [BW_BITS:0]   sum;
    logic               ok;

    always_comb begin
        over = |cmp[31:BW_BITS];
        d_m  = swp[BW_BITS-1:0];
        a_m  = cmp[BW_BITS-1:0];
        diff = '0;
        sum  = '0;
        ok   = 1'b0;
        nxt  = cur;
        if (!over) begin
            if (a_m >= d_m) begin
                diff = a_m - d_m;
                ok   = (cur >= diff);
                if (ok) nxt = cur - diff;
            end else begin
                diff = d_m - a_m;
                sum  = {1'b0, cur} + {1'b0, diff};
                ok   = !sum[BW_BITS];
                if (ok) nxt = sum[BW_BITS-1:0];
            end
        end
        ret = ok ? cmp : {{HI_W{1'b0}}, cur};
    end
endmodule

// File: rtl/irm_chan_rule.sv
`timescale 1ns/1ps
module irm_chan_rule #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] swp,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] nxt,
    output logic [W-1:0] ret
);
    logic [W-1:0] flip;
    logic         agree;

    always_comb begin
        flip  = cmp ^ swp;
        agree = (((cmp ^ cur) & flip) == '0);
        nxt   = agree ? (cur ^ flip) : cur;
        ret   = agree ? cmp : cur;
    end
endmodule

// File: rtl/irm_lock_regs.sv
`timescale 1ns/1ps
module irm_lock_regs
    import irm_pkg::*;
#(
    parameter int AW = 12,
    parameter logic [AW-1:0] MGR_OFS  = 12'h21C,
    parameter logic [AW-1:0] BW_OFS   = 12'h220,
    parameter logic [AW-1:0] CHHI_OFS = 12'h224,
    parameter logic [AW-1:0] CHLO_OFS = 12'h228
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_ext,
    input  logic [63:0]   req_data,
    input  logic [63:0]   req_arg,
    output logic          rsp_valid,
    output logic [1:0]    rsp_rcode,
    output logic [63:0]   rsp_data
);
    localparam int NCH  = 2;
    localparam int QW   = 32;
    localparam int OW   = 2 * QW;
    localparam int HI_W = QW - BW_BITS;

    state_e state_q, state_n;

    logic [QW-1:0]      mgr_q, mgr_n;
    logic [BW_BITS-1:0] bw_q, bw_n;
    logic [QW-1:0]      chhi_q, chhi_n;
    logic [QW-1:0]      chlo_q, chlo_n;

    logic [OW-1:0] rsp_data_q, rsp_data_n;
    rcode_e        rsp_rc_q;

    op_e    op;
    tgt_e   tgt;
    rcode_e rc;
    logic   accept;
    logic   commit;

    logic [QW-1:0] d32, a32;

    assign op  = op_e'(req_op);
    assign d32 = req_data[QW-1:0];
    assign a32 = req_arg[QW-1:0];

    irm_decode #(
        .AW(AW), .MGR_OFS(MGR_OFS), .BW_OFS(BW_OFS),
        .CHHI_OFS(CHHI_OFS), .CHLO_OFS(CHLO_OFS)
    ) u_decode (
        .op(op), .addr(req_addr), .ext(req_ext), .tgt(tgt), .rc(rc)
    );

    // bandwidth rule
    logic [BW_BITS-1:0] bw_rule_nxt;
    logic [QW-1:0]      bw_rule_ret;

    irm_bw_rule u_bw (
        .cur(bw_q), .swp(d32), .cmp(a32), .nxt(bw_rule_nxt), .ret(bw_rule_ret)
    );

    // per-word channel rules; index 0 is the high word carrying channel 31
    logic [QW-1:0] ch_cur [NCH];
    logic [QW-1:0] ch_swp [NCH];
    logic [QW-1:0] ch_nxt [NCH];
    logic [QW-1:0] ch_ret [NCH];

    assign ch_cur[0] = chhi_q;
    assign ch_cur[1] = chlo_q;

    generate
        for (genvar gi = 0; gi < NCH; gi++) begin : g_word
            if (gi == 0) begin : g_guard
                assign ch_swp[gi] = {d32[QW-1:1], 1'b0};
            end else begin : g_plain
                assign ch_swp[gi] = d32;
            end
            irm_chan_rule #(.W(QW)) u_word (
                .cur(ch_cur[gi]), .swp(ch_swp[gi]), .cmp(a32),
                .nxt(ch_nxt[gi]), .ret(ch_ret[gi])
            );
        end
    endgenerate

    // 64-bit rule over {high, low}; channel 31 sits at bit QW
    logic [OW-1:0] pair_cur, pair_swp, pair_nxt, pair_ret;

    assign pair_cur = {chhi_q, chlo_q};
    assign pair_swp = {req_data[OW-1:QW+1], 1'b0, req_data[QW-1:0]};

    irm_chan_rule #(.W(OW)) u_pair (
        .cur(pair_cur), .swp(pair_swp), .cmp(req_arg),
        .nxt(pair_nxt), .ret(pair_ret)
    );

    assign accept = req_valid && (state_q == ST_IDLE) && !bus_rst;
    assign commit = accept && (rc == RC_COMPLETE);

    // next register values and reply word
    always_comb begin
        mgr_n      = mgr_q;
        bw_n       = bw_q;
        chhi_n     = chhi_q;
        chlo_n     = chlo_q;
        rsp_data_n = '0;
        if (commit) begin
            unique case (op)
                OP_READ: begin
                    unique case (tgt)
                        TGT_MGR:  rsp_data_n = {{QW{1'b0}}, mgr_q};
                        TGT_BW:   rsp_data_n = {{QW{1'b0}}, {HI_W{1'b0}}, bw_q};
                        TGT_CHHI: rsp_data_n = {{QW{1'b0}}, chhi_q};
                        TGT_CHLO: rsp_data_n = {{QW{1'b0}}, chlo_q};
                        default:  rsp_data_n = '0;
                    endcase
                end
                OP_LOCK32: begin
                    unique case (tgt)
                        TGT_MGR: begin
                            rsp_data_n = {{QW{1'b0}}, mgr_q};
                            if (mgr_q == a32) mgr_n = d32;
                        end
                        TGT_BW: begin
                            rsp_data_n = {{QW{1'b0}}, bw_rule_ret};
                            bw_n       = bw_rule_nxt;
                        end
                        TGT_CHHI: begin
                            rsp_data_n = {{QW{1'b0}}, ch_ret[0]};
                            chhi_n     = ch_nxt[0];
                        end
                        TGT_CHLO: begin
                            rsp_data_n = {{QW{1'b0}}, ch_ret[1]};
                            chlo_n     = ch_nxt[1];
                        end
                        default: rsp_data_n = '0;
                    endcase
                end
                OP_LOCK64: begin
                    rsp_data_n = pair_ret;
                    chhi_n     = pair_nxt[OW-1:QW];
                    chlo_n     = pair_nxt[QW-1:0];
                end
                default: rsp_data_n = '0;
            endcase
        end
    end

    // state transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   state_n = bus_rst ? ST_RELOAD : (accept ? ST_REPLY : ST_IDLE);
            ST_REPLY:  state_n = bus_rst ? ST_RELOAD : ST_IDLE;
            ST_RELOAD: state_n = bus_rst ? ST_RELOAD : ST_IDLE;
            default:   state_n = ST_RELOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RELOAD;
        else        state_q <= state_n;
    end

    // resource registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || bus_rst) begin
            mgr_q  <= MGR_INIT;
            bw_q   <= BW_INIT;
            chhi_q <= CHHI_INIT;
            chlo_q <= CHLO_INIT;
        end else begin
            mgr_q  <= mgr_n;
            bw_q   <= bw_n;
            chhi_q <= chhi_n;
            chlo_q <= chlo_n;
        end
    end

    // response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data_q <= '0;
            rsp_rc_q   <= RC_COMPLETE;
        end else if (accept) begin
            rsp_data_q <= rsp_data_n;
            rsp_rc_q   <= rc;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_REPLY);
        rsp_rcode = rsp_rc_q;
        rsp_data  = rsp_data_q;
    end
endmodule

// File: rtl/irm_lock_regs_chk.sv
`timescale 1ns/1ps
module irm_lock_regs_chk
    import irm_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [1:0]          req_op,
    input logic                rsp_valid,
    input logic [1:0]          rsp_rcode,
    input logic [31:0]         mgr,
    input logic [BW_BITS-1:0]  bw,
    input logic [31:0]         chhi,
    input logic [31:0]         chlo
);
    logic taken;
    assign taken = req_valid && req_ready && !bus_rst;

    AST_RELOAD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (mgr == 32'h3F && bw == 13'd4915 &&
                     chhi == 32'hFFFF_FFFE && chlo == 32'hFFFF_FFFF)); // R1

    AST_REPLY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> rsp_valid); // R2

    AST_REPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2

    AST_RCODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rcode != 2'd3)); // R3

    AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && req_op == 2'd1) |=>
            ($stable(mgr) && $stable(bw) && $stable(chhi) && $stable(chlo))); // R5

    AST_BW_LOCK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bw != $past(bw)) |-> ($past(bus_rst) ||
            ($past(taken) && $past(req_op) == 2'd2))); // R9

    AST_CH31_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !chhi[0]); // R12

    AST_DROP_ON_BUSRST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !rsp_valid); // R14
endmodule

bind irm_lock_regs irm_lock_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_rcode(rsp_rcode),
    .mgr(mgr_q), .bw(bw_q), .chhi(chhi_q), .chlo(chlo_q)
);

// File: tb/test_irm_lock_regs.sv
`timescale 1ns/1ps
module test_irm_lock_regs;
    localparam int A_MGR = 'h21C, A_BW = 'h220, A_HI = 'h224, A_LO = 'h228;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_ext = '0;
    logic [63:0] req_data = '0;
    logic [63:0] req_arg = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_rcode;
    logic [63:0] rsp_data;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int unsigned m_mgr, m_bw, m_hi, m_lo;

    always #10 clk = ~clk;

    irm_lock_regs i_irm_lock_regs (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_ext(req_ext), .req_data(req_data),
        .req_arg(req_arg), .rsp_valid(rsp_valid), .rsp_rcode(rsp_rcode),
        .rsp_data(rsp_data)
    );

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_defaults();
        m_mgr = 32'h3F; m_bw = 4915; m_hi = 32'hFFFF_FFFE; m_lo = 32'hFFFF_FFFF;
    endfunction

    function automatic void model(input int op, input int addr, input int ext,
                                  input longint unsigned d, input longint unsigned a,
                                  output int rc, output longint unsigned rd);
        bit known;
        int unsigned d32, a32, dm, amt, x, flip, cur;
        longint unsigned c64, x64, f64;
        known = (addr == A_MGR) || (addr == A_BW) || (addr == A_HI) || (addr == A_LO);
        d32 = d[31:0]; a32 = a[31:0];
        rd = 0;
        if (addr % 4 != 0)                 rc = 1;
        else if (!known)                   rc = 2;
        else if (op == 0) begin
            rc = 0;
            rd = (addr == A_MGR) ? m_mgr : (addr == A_BW) ? m_bw :
                 (addr == A_HI) ? m_hi : m_lo;
        end
        else if (op == 1)                  rc = 1;
        else if (ext != 2)                 rc = 1;
        else if (op == 3 && addr != A_HI)  rc = 1;
        else if (op == 3) begin
            rc  = 0;
            c64 = {m_hi, m_lo};
            x64 = d & ~(64'd1 << 32);
            f64 = a ^ x64;
            if ((a & f64) == (c64 & f64)) begin
                c64 = c64 ^ f64; rd = a;
                m_hi = c64[63:32]; m_lo = c64[31:0];
            end else rd = c64;
        end else begin
            rc = 0;
            if (addr == A_MGR) begin
                rd = m_mgr;
                if (m_mgr == a32) m_mgr = d32;
            end else if (addr == A_BW) begin
                dm = d32 % 8192;
                if (a32 > 8191) rd = m_bw;
                else if (a32 >= dm) begin
                    amt = a32 - dm;
                    if (m_bw >= amt) begin m_bw = m_bw - amt; rd = a32; end
                    else rd = m_bw;
                end else begin
                    amt = dm - a32;
                    if (m_bw + amt < 8192) begin m_bw = m_bw + amt; rd = a32; end
                    else rd = m_bw;
                end
            end else begin
                cur  = (addr == A_HI) ? m_hi : m_lo;
                x    = (addr == A_HI) ? (d32 & 32'hFFFF_FFFE) : d32;
                flip = a32 ^ x;
                if ((a32 & flip) == (cur & flip)) begin
                    cur = cur ^ flip; rd = a32;
                end else rd = cur;
                if (addr == A_HI) m_hi = cur; else m_lo = cur;
            end
        end
    endfunction

    task automatic xfer(input string req, input int op, input int addr, input int ext,
                        input longint unsigned d, input longint unsigned a);
        int rc;
        longint unsigned rd;
        model(op, addr, ext, d, a, rc, rd);
        @(negedge clk);
        check("R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_op = op[1:0]; req_addr = addr[11:0];
        req_ext = ext[3:0]; req_data = d; req_arg = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "reply valid", rsp_valid, 1);
        check("R2", "ready during reply", req_ready, 0);
        check(req, "rcode", rsp_rcode, rc);
        check(req, "data", rsp_data, rd);
        @(negedge clk);
        check("R2", "reply one cycle only", rsp_valid, 0);
    endtask

    task automatic read_all(input string req);
        xfer(req, 0, A_MGR, 0, 0, 0);
        xfer(req, 0, A_BW,  0, 0, 0);
        xfer(req, 0, A_HI,  0, 0, 0);
        xfer(req, 0, A_LO,  0, 0, 0);
    endtask

    initial begin
        model_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reply idle after reset", rsp_valid, 0);
        read_all("R1");

        // R3 unknown offsets, R4 misalignment
        xfer("R3", 0, 'h200, 0, 0, 0);
        xfer("R3", 2, 'h300, 2, 5, 5);
        xfer("R4", 0, 'h222, 0, 0, 0);
        xfer("R4", 2, 'h21D, 2, 7, 32'h3F);
        // R5 writes are refused
        xfer("R5", 1, A_MGR, 0, 9, 0);
        xfer("R5", 1, A_LO,  0, 0, 0);
        xfer("R5", 1, 'h100, 0, 1, 0);
        // R6 wrong extended code
        xfer("R6", 2, A_BW, 1, 0, 4915);
        xfer("R6", 3, A_HI, 3, 0, 0);
        read_all("R5");

        // R7 manager compare-swap
        xfer("R7", 2, A_MGR, 2, 5, 32'h3F);
        xfer("R7", 2, A_MGR, 2, 7, 32'h3F);
        xfer("R7", 0, A_MGR, 0, 0, 0);

        // R8..R10 bandwidth
        xfer("R8",  2, A_BW, 2, 0, 32'h2000);
        xfer("R9",  2, A_BW, 2, 4815, 4915);
        xfer("R9",  2, A_BW, 2, 0, 5000);
        xfer("R8",  2, A_BW, 2, 32'hFFFF_E000, 100);
        xfer("R10", 2, A_BW, 2, 200, 0);
        xfer("R10", 2, A_BW, 2, 32'h1FFF, 0);
        xfer("R9",  2, A_BW, 2, 4915, 4915);
        xfer("R9",  0, A_BW, 0, 0, 0);

        // R11 channel words
        xfer("R11", 2, A_LO, 2, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        xfer("R11", 2, A_LO, 2, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        xfer("R11", 2, A_HI, 2, 32'h7FFF_FFFE, 32'hFFFF_FFFE);
        xfer("R11", 2, A_LO, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
        // R12 channel 31 guarded
        xfer("R12", 2, A_HI, 2, 32'h7FFF_FFFF, 32'h7FFF_FFFE);
        xfer("R12", 2, A_HI, 2, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        xfer("R12", 0, A_HI, 0, 0, 0);

        // R13 64-bit pair
        xfer("R13", 3, A_HI, 2, 64'h7FFF_FFFE_7FFF_FFFF, 64'h7FFF_FFFE_FFFF_FFFF);
        xfer("R13", 3, A_HI, 2, 64'h7FFF_FFFE_FFFF_FFFF, 64'h7FFF_FFFE_FFFF_FFFF);
        xfer("R13", 3, A_HI, 2, 64'h0000_0001_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF);
        xfer("R13", 3, A_BW, 2, 0, 0);
        xfer("R13", 3, A_LO, 2, 0, 0);
        read_all("R13");

        // R14 / R1 bus reset drops a request and reloads defaults
        @(negedge clk);
        bus_rst = 1'b1; req_valid = 1'b1; req_op = 2'd2; req_addr = A_MGR[11:0];
        req_ext = 4'd2; req_data = 64'd1; req_arg = 64'd5;
        @(negedge clk);
        bus_rst = 1'b0; req_valid = 1'b0;
        model_defaults();
        check("R14", "no reply to dropped request", rsp_valid, 0);
        check("R1", "not ready in reload", req_ready, 0);
        @(negedge clk);
        check("R1", "ready after reload", req_ready, 1);
        read_all("R1");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule